// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM

This block is a synchronous static memory with two data buses: one that carries data in and one that carries data out. A single address bus serves both. On the rising clock edge it carries a read address, and on the falling edge it carries a write address. Every address holds a pair of 18-bit words. Both reads and writes move that pair as a two-word burst on consecutive clock edges, so each port reaches double data rate. Because the buses never change direction, no turnaround cycle is needed.

The rising and falling clock edges play the roles of the two complementary input clocks. Read and write each have an active-low select, so several of these blocks can share the buses to extend depth. Each 9-bit half of each write word has its own active-low enable. A write lands in the array only after its second word has been captured. A read issued in the same cycle sees that write through a bypass path. Read data comes out of registers one clock cycle after the read address is sampled, and a valid strobe marks it.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is low and after its release, `rdValid` is 0 until a read has been selected.
- R2: With `wrSelN` low at a rising edge, the first write word is taken from `wrData` at that rising edge. The second word and the write address are taken at the following falling edge. The pair is stored at that address, with the first word as the low half of the pair.
- R3: With `rdSelN` low at rising edge n, the read address is taken from `addr` at that edge. During the high phase after rising edge n+1, `rdData` carries the stored first word. During the low phase after it, `rdData` carries the second word. `rdValid` is 1 for that whole cycle.
- R4: A read and a write to different addresses in the same cycle both complete, and neither disturbs the other.
- R5: A read issued at the same rising edge as a write to the same address returns the newly written pair, including any halves that were masked.
- R6: `byteWrN` is sampled with each write word. Bit 0 low enables bits 8:0 of that word and bit 1 low enables bits 17:9. A half whose bit is 1 keeps its old content.
- R7: With `wrSelN` high at a rising edge, nothing is written in that cycle, whatever the values on `addr`, `wrData` and `byteWrN`.
- R8: With `rdSelN` high at rising edge n, `rdValid` is 0 in the cycle after rising edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The rising edge samples the read address and the first write word. The falling edge samples the write address and the second write word. |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Shared address: read address at the rising edge, write address at the falling edge |
| rdSelN | input | 1 | Active-low read select, sampled at the rising edge |
| wrSelN | input | 1 | Active-low write select, sampled at the rising edge |
| wrData | input | 18 | Write data, one burst word per clock edge |
| byteWrN | input | 2 | Active-low half-word write enables, one set per burst word |
| rdData | output | 18 | Read data: first word while clk is high, second word while clk is low |
| rdValid | output | 1 | High for the clock cycle that carries a read burst |

## Verification
The hardest case to reach is a read that collides with a write still waiting to be committed. The write's second word and address arrive only at the falling edge. The read must then pick up that pair through the bypass before the array holds it. The stimulus issues a read and a masked write to the same address at one rising edge, after filling the location with a known pattern. The expected pair therefore mixes old and new halves. A long stretch of random interleaved reads and writes over a small address set makes such collisions, and back-to-back hits on the same address, happen many more times.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int WORD_W = 18;
  localparam int HALF_W = 9;
  localparam int PAIR_W = 2 * WORD_W;
  localparam int LANES  = PAIR_W / HALF_W;

  typedef struct packed {
    logic commitWr;  // pending write pair is complete, write it this rising edge
    logic loadRd;    // a read was accepted last rising edge, load output pair now
  } ctrlStb_t;
endpackage

// File: rtl/qdr_ctrl.sv
module qdr_ctrl
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdSelN,
  input  logic              wrSelN,
  output ctrlStb_t          stb,
  output logic [ADDR_W-1:0] rdAddrQ,
  output logic [ADDR_W-1:0] wrAddrQ,
  output logic              rdValid
);
  logic rdArm;
  logic wrArm;
  logic wrPend;

  // rising edge: read command + address, write command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdArm   <= 1'b0;
      wrArm   <= 1'b0;
      rdValid <= 1'b0;
      rdAddrQ <= '0;
    end else begin
      rdArm   <= !rdSelN;
      wrArm   <= !wrSelN;
      rdValid <= rdArm;
      rdAddrQ <= addr;
    end
  end

  // falling edge: write address belongs to the command armed at the rising edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend  <= 1'b0;
      wrAddrQ <= '0;
    end else begin
      wrPend <= wrArm;
      if (wrArm) wrAddrQ <= addr;
    end
  end

  assign stb.commitWr = wrPend;
  assign stb.loadRd   = rdArm;
endmodule

// File: rtl/qdr_datapath.sv
module qdr_datapath
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        byteWrN,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] wrWord0, wrWord1;
  logic [1:0]        laneEn0, laneEn1;
  logic [PAIR_W-1:0] wrPair, rdMerged, pairQ;
  logic [LANES-1:0]  laneEn;
  logic [WORD_W-1:0] hiWordQ;

  always_ff @(posedge clk) begin
    wrWord0 <= wrData;
    laneEn0 <= ~byteWrN;
  end

  always_ff @(negedge clk) begin
    wrWord1 <= wrData;
    laneEn1 <= ~byteWrN;
  end

  assign wrPair = {wrWord1, wrWord0};
  assign laneEn = {laneEn1, laneEn0};

  // one storage array per 9-bit lane, so half-word masking is a plain enable
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [HALF_W-1:0] laneMem [DEPTH];
    logic              laneWe;
    assign laneWe = stb.commitWr && laneEn[g];

    always_ff @(posedge clk) begin
      if (laneWe) laneMem[wrAddr] <= wrPair[g*HALF_W +: HALF_W];
    end

    // bypass: the write committing at this edge is not yet in the array
    assign rdMerged[g*HALF_W +: HALF_W] =
      (laneWe && (wrAddr == rdAddr)) ? wrPair[g*HALF_W +: HALF_W] : laneMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (stb.loadRd) pairQ <= rdMerged;
  end

  always_ff @(negedge clk) begin
    hiWordQ <= pairQ[PAIR_W-1:WORD_W];
  end

  // double-data-rate output select
  assign rdData = clk ? pairQ[WORD_W-1:0] : hiWordQ;
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [17:0]       wrData,
  input  logic [1:0]        byteWrN,
  output logic [17:0]       rdData,
  output logic              rdValid
);
  ctrlStb_t          ctrlStb;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [ADDR_W-1:0] wrAddrQ;

  qdr_ctrl #(.ADDR_W(ADDR_W)) ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .rdSelN  (rdSelN),
    .wrSelN  (wrSelN),
    .stb     (ctrlStb),
    .rdAddrQ (rdAddrQ),
    .wrAddrQ (wrAddrQ),
    .rdValid (rdValid)
  );

  qdr_datapath #(.ADDR_W(ADDR_W)) dataInst (
    .clk     (clk),
    .stb     (ctrlStb),
    .rdAddr  (rdAddrQ),
    .wrAddr  (wrAddrQ),
    .wrData  (wrData),
    .byteWrN (byteWrN),
    .rdData  (rdData)
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk
  import qdr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rdSelN,
  input logic        wrSelN,
  input logic        rdValid,
  input logic [17:0] rdData,
  input ctrlStb_t    ctrlStb
);
  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_VALID_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0) |-> !$isunknown(rdValid));  // R1

  AST_VALID_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (rdValid == !$past(rdSelN, 2)));  // R8

  AST_COMMIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt != 2'd0) && ctrlStb.commitWr) |-> !$past(wrSelN));  // R7

  AST_BURST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt != 2'd0) && rdValid) |-> !$isunknown(rdData));  // R3
endmodule

bind qdr_burst_sram qdr_burst_sram_chk chkInst (.*);

// File: tb/qdr_burst_sram_test.sv
module qdr_burst_sram_test;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          rdSelN, wrSelN;
  logic [17:0]   wrData;
  logic [1:0]    byteWrN;
  logic [17:0]   rdData;
  logic          rdValid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [35:0] refMem [0:31];
  bit          pendValid = 1'b0;
  logic [35:0] pendExp;
  string       pendTag;

  qdr_burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .wrData(wrData), .byteWrN(byteWrN), .rdData(rdData), .rdValid(rdValid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] maskWord(input logic [17:0] old, input logic [17:0] nw, input logic [1:0] bn);
    logic [17:0] r = old;
    if (!bn[0]) r[8:0]  = nw[8:0];
    if (!bn[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  // one clock cycle; entered just after a falling edge
  task automatic doCycle(input bit rEn, input logic [AW-1:0] rA,
                         input bit wEn, input logic [AW-1:0] wA,
                         input logic [17:0] d0, input logic [1:0] b0n,
                         input logic [17:0] d1, input logic [1:0] b1n,
                         input string tag);
    addr = rA; rdSelN = !rEn; wrSelN = !wEn; wrData = d0; byteWrN = b0n;
    @(posedge clk); #1;
    check(rdValid === pendValid, pendValid ? "R3 valid" : "R8 valid",
          {35'd0, rdValid}, {35'd0, pendValid});
    if (pendValid)
      check(rdData === pendExp[17:0], {pendTag, " word0"}, {18'd0, rdData}, {18'd0, pendExp[17:0]});
    addr = wA; wrData = d1; byteWrN = b1n;
    @(negedge clk); #1;
    if (pendValid)
      check(rdData === pendExp[35:18], {pendTag, " word1"}, {18'd0, rdData}, {18'd0, pendExp[35:18]});
    if (wEn)
      refMem[wA[4:0]] = {maskWord(refMem[wA[4:0]][35:18], d1, b1n),
                         maskWord(refMem[wA[4:0]][17:0], d0, b0n)};
    pendValid = rEn;
    if (rEn) pendExp = refMem[rA[4:0]];
    pendTag = tag;
  endtask

  task automatic idle();
    doCycle(0, '0, 0, '0, '0, 2'b11, '0, 2'b11, "R8");
  endtask

  task automatic testReset();
    rstN = 1'b0; rdSelN = 1'b1; wrSelN = 1'b1; addr = '0; wrData = '0; byteWrN = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    check(rdValid === 1'b0, "R1 in reset", {35'd0, rdValid}, 36'd0);
    rstN = 1'b1;
    idle();
    check(rdValid === 1'b0, "R1 after release", {35'd0, rdValid}, 36'd0);
  endtask

  task automatic testFillRead();
    for (int i = 0; i < 32; i++)
      doCycle(0, '0, 1, AW'(i), 18'(i * 1111 + 5), 2'b00, 18'(18'h3ffff - i * 777), 2'b00, "R2");
    for (int i = 0; i < 32; i++)
      doCycle(1, AW'(i), 0, '0, '0, 2'b11, '0, 2'b11, "R2 readback");
    idle();
  endtask

  task automatic testConcurrent();
    doCycle(1, AW'(3), 1, AW'(4), 18'h12345, 2'b00, 18'h2abcd, 2'b00, "R4 read");
    doCycle(1, AW'(4), 1, AW'(3), 18'h0f0f0, 2'b00, 18'h30303, 2'b00, "R4 read new");
    doCycle(1, AW'(3), 0, '0, '0, 2'b11, '0, 2'b11, "R4 read other");
    idle();
  endtask

  task automatic testBypass();
    doCycle(1, AW'(7), 1, AW'(7), 18'h1beef, 2'b00, 18'h0cafe, 2'b00, "R5 same cycle");
    doCycle(1, AW'(8), 1, AW'(8), 18'h3ffff, 2'b01, 18'h00000, 2'b10, "R5 masked same cycle");
    idle();
  endtask

  task automatic testByteMask();
    doCycle(0, '0, 1, AW'(10), 18'h3ffff, 2'b00, 18'h3ffff, 2'b00, "R6 prefill");
    doCycle(0, '0, 1, AW'(10), 18'h00000, 2'b10, 18'h00000, 2'b01, "R6 partial");
    doCycle(1, AW'(10), 0, '0, '0, 2'b11, '0, 2'b11, "R6 halves");
    doCycle(0, '0, 1, AW'(10), 18'h15555, 2'b11, 18'h2aaaa, 2'b11, "R6 none");
    doCycle(1, AW'(10), 0, '0, '0, 2'b11, '0, 2'b11, "R6 no lanes");
    idle();
  endtask

  task automatic testWriteDeselect();
    doCycle(0, '0, 0, AW'(12), 18'h11111, 2'b00, 18'h22222, 2'b00, "R7 ignored");
    doCycle(1, AW'(12), 0, AW'(12), 18'h33333, 2'b00, 18'h01234, 2'b00, "R7 unchanged");
    idle();
  endtask

  task automatic testReadDeselect();
    doCycle(0, AW'(5), 1, AW'(6), 18'h0aaaa, 2'b00, 18'h05555, 2'b00, "R8");
    doCycle(0, AW'(6), 0, '0, '0, 2'b11, '0, 2'b11, "R8");
    doCycle(1, AW'(6), 0, '0, '0, 2'b11, '0, 2'b11, "R8 then read");
    idle();
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra = AW'($urandom_range(0, 7));
      logic [AW-1:0] wa = AW'($urandom_range(0, 7));
      doCycle(($urandom % 3) != 0, ra, ($urandom % 2) == 0, wa,
              18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom), "R4 random");
    end
    idle();
    idle();
  endtask

  initial begin
    testReset();
    testFillRead();
    testConcurrent();
    testBypass();
    testByteMask();
    testWriteDeselect();
    testReadDeselect();
    testRandom();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule